// File: doc/BRIEF.md
# System-Management Entry Register State Unit

This block keeps a small slice of processor architectural state: the instruction pointer, the flags word, two control registers, a debug-control register, a programmable entry base address and six segment registers. Each segment register holds a selector, a base, a limit and an attribute byte. When the entry pulse arrives, the whole slice is forced into the fixed system-management entry state, which is built from the programmable entry base.

Outside entry, the block services two kinds of request. A segment-load request forms the base of the chosen segment in real-address style, as the selector times 16. A control-transfer request updates the instruction pointer, and a far transfer also reloads the code segment. The instruction pointer is cut to 16 bits unless the transfer carries a 32-bit operand-size override. The block also drives the linear fetch address, which is the code-segment base plus the instruction pointer.

All requests are single-cycle, valid-qualified pulses. Every state change shows at the outputs after the next rising clock edge.

Top module: `sysmgmt_entry_state`

## Requirements
- R1: After reset the state is as follows. Instruction pointer is 0x00000000. Flags are 0x00000002. CR0 is 0x8000003F, CR4 is 0x00000620 and DR7 is 0x00000455. The entry base is 0x00030000. Every selector and every base is 0. Every limit is 0x0000FFFF and every attribute byte is 0x93.
- R2: The cycle after an entry pulse, the instruction pointer is 0x00008000 and the flags are 0x00000002. The code selector is bits [19:4] of the entry base, and the code base equals the entry base.
- R3: On entry, the five data and stack segments get selector 0 and base 0. All six limits become 0xFFFFFFFF. No attribute byte changes.
- R4: On entry, CR0 bits 31, 3, 2 and 0 are cleared and all other CR0 bits keep their value. CR4 becomes 0 and DR7 becomes 0x00000400.
- R5: The segment index is encoded ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. A segment load sets the selector of the indexed segment and sets its base to the selector shifted left by 4. Limit and attributes stay as they were. Index 6 or 7 changes nothing.
- R6: A control transfer without the operand-size override sets the instruction pointer to the low 16 bits of the target, with the upper 16 bits zero.
- R7: A near transfer with the override sets the instruction pointer to the full 32-bit target and leaves the code segment unchanged.
- R8: A far transfer sets the code selector to the transfer selector and the code base to that selector shifted left by 4. Limit and attributes stay as they were, and the instruction pointer follows R6 or R7.
- R9: The fetch address is the code base plus the instruction pointer, modulo 2^32.
- R10: A write to the entry-base port takes effect on the next edge, except in the cycle of an entry pulse. In that cycle the write is dropped, and the entry uses the entry base held before the pulse.
- R11: An entry pulse overrides any segment load or transfer in the same cycle. A far transfer overrides a same-cycle segment load to CS. A segment load to any other segment and a transfer in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_entry_i | input | 1 | Entry pulse |
| smbase_wr_i | input | 1 | Entry-base write strobe |
| smbase_wdata_i | input | 32 | Entry-base write value |
| seg_ld_i | input | 1 | Segment-load request |
| seg_ld_idx_i | input | 3 | Segment index (ES=0, CS=1, SS=2, DS=3, FS=4, GS=5) |
| seg_ld_sel_i | input | 16 | Selector to load |
| xfer_i | input | 1 | Control-transfer request |
| xfer_far_i | input | 1 | Transfer also reloads the code segment |
| xfer_op32_i | input | 1 | Transfer carries a 32-bit operand-size override |
| xfer_sel_i | input | 16 | Code selector for a far transfer |
| xfer_ip_i | input | 32 | Target instruction pointer |
| eip_o | output | 32 | Instruction pointer |
| eflags_o | output | 32 | Flags word |
| cr0_o | output | 32 | Control register 0 |
| cr4_o | output | 32 | Control register 4 |
| dr7_o | output | 32 | Debug-control register |
| smbase_o | output | 32 | Entry base |
| seg_sel_o | output | 96 | Selectors, segment i at bits [16*i+15:16*i] |
| seg_base_o | output | 192 | Bases, segment i at bits [32*i+31:32*i] |
| seg_limit_o | output | 192 | Limits, segment i at bits [32*i+31:32*i] |
| seg_attr_o | output | 48 | Attribute bytes, segment i at bits [8*i+7:8*i] |
| fetch_addr_o | output | 32 | Linear fetch address |

## Verification
The hardest case to reach from the ports is a cycle where several sources compete for the same state. One such cycle carries an entry pulse together with an entry-base write, a segment load and a far transfer. Another carries a far transfer together with a segment load aimed at the code segment. The stimulus drives these combinations in single cycles. It then checks that the entry used the old entry base, that the dropped write never reached the register, and that the losing request left no trace in any selector or base. The 32-bit wrap of the fetch address is reached by a near transfer with the override to a target close to 2^32 while a non-zero code base is in place.

// File: rtl/sms_pkg.sv
package sms_pkg;
    localparam int XLEN    = 32;
    localparam int SEL_W   = 16;
    localparam int ATTR_W  = 8;
    localparam int NSEG    = 6;
    localparam int SIDX_W  = 3;
    localparam int SHIFT   = 4;
    localparam int PAD_W   = XLEN - SEL_W - SHIFT;
    localparam int IPLO_W  = 16;

    typedef enum logic [SIDX_W-1:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_idx_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [XLEN-1:0]   base;
        logic [XLEN-1:0]   limit;
        logic [ATTR_W-1:0] attr;
    } seg_t;

    typedef struct packed {
        logic [XLEN-1:0] eip;
        logic [XLEN-1:0] eflags;
        logic [XLEN-1:0] cr0;
        logic [XLEN-1:0] cr4;
        logic [XLEN-1:0] dr7;
        logic [XLEN-1:0] smbase;
    } ctrl_t;

    // CR0 bits forced low on entry: paging(31), task-switched(3), emulate(2), protect(0)
    localparam logic [XLEN-1:0] CR0_ENTRY_CLR = 32'h8000_000D;
    localparam logic [XLEN-1:0] ENTRY_EIP     = 32'h0000_8000;
    localparam logic [XLEN-1:0] ENTRY_FLAGS   = 32'h0000_0002;
    localparam logic [XLEN-1:0] ENTRY_DR7     = 32'h0000_0400;
    localparam logic [XLEN-1:0] FLAT_LIMIT    = 32'hFFFF_FFFF;

    function automatic logic [XLEN-1:0] real_base(input logic [SEL_W-1:0] sel);
        return {{PAD_W{1'b0}}, sel, {SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/sms_seg_slot.sv
module sms_seg_slot
    import sms_pkg::*;
#(
    parameter logic [XLEN-1:0]   LIMIT_RST = 32'h0000_FFFF,
    parameter logic [ATTR_W-1:0] ATTR_RST  = 8'h93
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_i,
    input  logic [SEL_W-1:0] entry_sel_i,
    input  logic [XLEN-1:0]  entry_base_i,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    output seg_t             seg_o
);
    seg_t seg_d, seg_q;

    always_comb begin
        seg_d = seg_q;
        if (entry_i) begin
            seg_d.sel   = entry_sel_i;
            seg_d.base  = entry_base_i;
            seg_d.limit = FLAT_LIMIT;
        end else if (wr_i) begin
            seg_d.sel  = wr_sel_i;
            seg_d.base = real_base(wr_sel_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q.sel   <= '0;
            seg_q.base  <= '0;
            seg_q.limit <= LIMIT_RST;
            seg_q.attr  <= ATTR_RST;
        end else begin
            seg_q <= seg_d;
        end
    end

    assign seg_o = seg_q;

    a_r3_entry_flat_limit: assert property (@(posedge clk) disable iff (!rst_n)
        entry_i |=> (seg_q.limit == FLAT_LIMIT) && (seg_q.attr == $past(seg_q.attr)));

    a_r5_real_base_form: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !entry_i) |=> (seg_q.base == real_base($past(wr_sel_i)))
                               && $stable(seg_q.limit) && $stable(seg_q.attr));

    a_r8_base_20bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !entry_i) |=> (seg_q.base[XLEN-1:SEL_W+SHIFT] == '0));
endmodule

// File: rtl/sms_ctrl_regs.sv
module sms_ctrl_regs
    import sms_pkg::*;
#(
    parameter logic [XLEN-1:0] EIP_RST    = 32'h0000_0000,
    parameter logic [XLEN-1:0] CR0_RST    = 32'h8000_003F,
    parameter logic [XLEN-1:0] CR4_RST    = 32'h0000_0620,
    parameter logic [XLEN-1:0] DR7_RST    = 32'h0000_0455,
    parameter logic [XLEN-1:0] SMBASE_RST = 32'h0003_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry_i,
    input  logic            xfer_i,
    input  logic            xfer_op32_i,
    input  logic [XLEN-1:0] xfer_ip_i,
    input  logic            smbase_wr_i,
    input  logic [XLEN-1:0] smbase_wdata_i,
    output ctrl_t           ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (entry_i) begin
            ctrl_d.eip    = ENTRY_EIP;
            ctrl_d.eflags = ENTRY_FLAGS;
            ctrl_d.cr0    = ctrl_q.cr0 & ~CR0_ENTRY_CLR;
            ctrl_d.cr4    = '0;
            ctrl_d.dr7    = ENTRY_DR7;
        end else begin
            if (xfer_i) begin
                ctrl_d.eip = xfer_op32_i ? xfer_ip_i
                                         : {{(XLEN-IPLO_W){1'b0}}, xfer_ip_i[IPLO_W-1:0]};
            end
            if (smbase_wr_i) begin
                ctrl_d.smbase = smbase_wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.eip    <= EIP_RST;
            ctrl_q.eflags <= ENTRY_FLAGS;
            ctrl_q.cr0    <= CR0_RST;
            ctrl_q.cr4    <= CR4_RST;
            ctrl_q.dr7    <= DR7_RST;
            ctrl_q.smbase <= SMBASE_RST;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

    a_r2_entry_ip_flags: assert property (@(posedge clk) disable iff (!rst_n)
        entry_i |=> (ctrl_q.eip == ENTRY_EIP) && (ctrl_q.eflags == ENTRY_FLAGS));

    a_r4_cr0_partial_clear: assert property (@(posedge clk) disable iff (!rst_n)
        entry_i |=> (ctrl_q.cr0 == ($past(ctrl_q.cr0) & ~CR0_ENTRY_CLR))
                    && (ctrl_q.cr4 == '0) && (ctrl_q.dr7 == ENTRY_DR7));

    a_r6_ip_truncate: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !entry_i && !xfer_op32_i) |=>
            (ctrl_q.eip == {{(XLEN-IPLO_W){1'b0}}, $past(xfer_ip_i[IPLO_W-1:0])}));

    a_r10_smbase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        entry_i |=> (ctrl_q.smbase == $past(ctrl_q.smbase)));
endmodule

// File: rtl/sysmgmt_entry_state.sv
module sysmgmt_entry_state
    import sms_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smi_entry_i,
    input  logic                   smbase_wr_i,
    input  logic [31:0]            smbase_wdata_i,
    input  logic                   seg_ld_i,
    input  logic [2:0]             seg_ld_idx_i,
    input  logic [15:0]            seg_ld_sel_i,
    input  logic                   xfer_i,
    input  logic                   xfer_far_i,
    input  logic                   xfer_op32_i,
    input  logic [15:0]            xfer_sel_i,
    input  logic [31:0]            xfer_ip_i,
    output logic [31:0]            eip_o,
    output logic [31:0]            eflags_o,
    output logic [31:0]            cr0_o,
    output logic [31:0]            cr4_o,
    output logic [31:0]            dr7_o,
    output logic [31:0]            smbase_o,
    output logic [6*16-1:0]        seg_sel_o,
    output logic [6*32-1:0]        seg_base_o,
    output logic [6*32-1:0]        seg_limit_o,
    output logic [6*8-1:0]         seg_attr_o,
    output logic [31:0]            fetch_addr_o
);
    ctrl_t ctrl;
    seg_t  seg_w [NSEG];

    logic ld_go, far_go;
    assign ld_go  = seg_ld_i && !smi_entry_i;
    assign far_go = xfer_i && xfer_far_i && !smi_entry_i;

    sms_ctrl_regs u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .entry_i        (smi_entry_i),
        .xfer_i         (xfer_i),
        .xfer_op32_i    (xfer_op32_i),
        .xfer_ip_i      (xfer_ip_i),
        .smbase_wr_i    (smbase_wr_i),
        .smbase_wdata_i (smbase_wdata_i),
        .ctrl_o         (ctrl)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam bit IS_CS = (g == int'(SEG_CS));
        logic             hit, wr;
        logic [SEL_W-1:0] wr_sel, ent_sel;
        logic [XLEN-1:0]  ent_base;

        assign hit = ld_go && (seg_ld_idx_i == SIDX_W'(g));
        if (IS_CS) begin : g_code
            assign wr       = far_go || hit;
            assign wr_sel   = far_go ? xfer_sel_i : seg_ld_sel_i;
            assign ent_sel  = ctrl.smbase[SEL_W+SHIFT-1:SHIFT];
            assign ent_base = ctrl.smbase;
        end else begin : g_data
            assign wr       = hit;
            assign wr_sel   = seg_ld_sel_i;
            assign ent_sel  = '0;
            assign ent_base = '0;
        end

        sms_seg_slot u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .entry_i      (smi_entry_i),
            .entry_sel_i  (ent_sel),
            .entry_base_i (ent_base),
            .wr_i         (wr),
            .wr_sel_i     (wr_sel),
            .seg_o        (seg_w[g])
        );

        assign seg_sel_o  [g*SEL_W  +: SEL_W]  = seg_w[g].sel;
        assign seg_base_o [g*XLEN   +: XLEN]   = seg_w[g].base;
        assign seg_limit_o[g*XLEN   +: XLEN]   = seg_w[g].limit;
        assign seg_attr_o [g*ATTR_W +: ATTR_W] = seg_w[g].attr;
    end

    assign eip_o        = ctrl.eip;
    assign eflags_o     = ctrl.eflags;
    assign cr0_o        = ctrl.cr0;
    assign cr4_o        = ctrl.cr4;
    assign dr7_o        = ctrl.dr7;
    assign smbase_o     = ctrl.smbase;
    assign fetch_addr_o = seg_w[SEG_CS].base + ctrl.eip;

    a_r2_code_from_smbase: assert property (@(posedge clk) disable iff (!rst_n)
        smi_entry_i |=> (seg_w[SEG_CS].base == $past(ctrl.smbase))
                        && (seg_w[SEG_CS].sel == $past(ctrl.smbase[SEL_W+SHIFT-1:SHIFT])));

    a_r11_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        smi_entry_i |=> (seg_w[SEG_DS].base == '0) && (ctrl.eip == ENTRY_EIP));

    a_r7_near_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !xfer_far_i && !smi_entry_i && !(seg_ld_i && seg_ld_idx_i == SEG_CS))
            |=> $stable(seg_w[SEG_CS].sel) && $stable(seg_w[SEG_CS].base));
endmodule

// File: tb/sysmgmt_entry_state_test.sv
module sysmgmt_entry_state_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smi_entry_i = 1'b0;
    logic        smbase_wr_i = 1'b0;
    logic [31:0] smbase_wdata_i = '0;
    logic        seg_ld_i = 1'b0;
    logic [2:0]  seg_ld_idx_i = '0;
    logic [15:0] seg_ld_sel_i = '0;
    logic        xfer_i = 1'b0;
    logic        xfer_far_i = 1'b0;
    logic        xfer_op32_i = 1'b0;
    logic [15:0] xfer_sel_i = '0;
    logic [31:0] xfer_ip_i = '0;
    logic [31:0] eip_o, eflags_o, cr0_o, cr4_o, dr7_o, smbase_o, fetch_addr_o;
    logic [95:0]  seg_sel_o;
    logic [191:0] seg_base_o, seg_limit_o;
    logic [47:0]  seg_attr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam int ES = 0, CS = 1, SS = 2, DS = 3, FS = 4, GS = 5;

    always #10 clk = ~clk;

    sysmgmt_entry_state uut (.*);

    function automatic logic [31:0] sel_of(int i);  return {16'h0, seg_sel_o[i*16 +: 16]}; endfunction
    function automatic logic [31:0] base_of(int i); return seg_base_o[i*32 +: 32]; endfunction
    function automatic logic [31:0] lim_of(int i);  return seg_limit_o[i*32 +: 32]; endfunction
    function automatic logic [31:0] attr_of(int i); return {24'h0, seg_attr_o[i*8 +: 8]}; endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        smi_entry_i = 0; smbase_wr_i = 0; seg_ld_i = 0; xfer_i = 0;
        xfer_far_i = 0; xfer_op32_i = 0;
    endtask

    // inputs set after a falling edge, captured at the rising edge, observed at the next falling edge
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        chk("R1 eip", eip_o, 32'h0);
        chk("R1 eflags", eflags_o, 32'h2);
        chk("R1 cr0", cr0_o, 32'h8000_003F);
        chk("R1 cr4", cr4_o, 32'h0000_0620);
        chk("R1 dr7", dr7_o, 32'h0000_0455);
        chk("R1 smbase", smbase_o, 32'h0003_0000);
        for (int i = 0; i < 6; i++) begin
            chk("R1 sel", sel_of(i), 32'h0);
            chk("R1 base", base_of(i), 32'h0);
            chk("R1 limit", lim_of(i), 32'h0000_FFFF);
            chk("R1 attr", attr_of(i), 32'h93);
        end
    endtask

    task automatic t_seg_load();
        seg_ld_i = 1; seg_ld_idx_i = 3'd3; seg_ld_sel_i = 16'h1234;
        step();
        chk("R5 ds sel", sel_of(DS), 32'h1234);
        chk("R5 ds base", base_of(DS), 32'h0001_2340);
        chk("R5 ds limit kept", lim_of(DS), 32'h0000_FFFF);
        chk("R5 ds attr kept", attr_of(DS), 32'h93);
        chk("R5 es untouched", base_of(ES), 32'h0);
        seg_ld_i = 1; seg_ld_idx_i = 3'd7; seg_ld_sel_i = 16'hFFFF;
        step();
        for (int i = 0; i < 6; i++) begin
            chk("R5 idx7 no effect", sel_of(i), (i == DS) ? 32'h1234 : 32'h0);
        end
        seg_ld_i = 1; seg_ld_idx_i = 3'd5; seg_ld_sel_i = 16'hFFFF;
        step();
        chk("R5 gs base max", base_of(GS), 32'h000F_FFF0);
    endtask

    task automatic t_entry();
        smi_entry_i = 1;
        step();
        chk("R2 eip", eip_o, 32'h0000_8000);
        chk("R2 eflags", eflags_o, 32'h2);
        chk("R2 cs sel", sel_of(CS), 32'h3000);
        chk("R2 cs base", base_of(CS), 32'h0003_0000);
        for (int i = 0; i < 6; i++) begin
            if (i != CS) begin
                chk("R3 sel zero", sel_of(i), 32'h0);
                chk("R3 base zero", base_of(i), 32'h0);
            end
            chk("R3 flat limit", lim_of(i), 32'hFFFF_FFFF);
            chk("R3 attr kept", attr_of(i), 32'h93);
        end
        chk("R4 cr0", cr0_o, 32'h0000_0032);
        chk("R4 cr4", cr4_o, 32'h0);
        chk("R4 dr7", dr7_o, 32'h0000_0400);
        chk("R9 fetch after entry", fetch_addr_o, 32'h0003_8000);
    endtask

    task automatic t_xfer();
        xfer_i = 1; xfer_ip_i = 32'hABCD_1234;
        step();
        chk("R6 near trunc", eip_o, 32'h0000_1234);
        chk("R9 fetch near", fetch_addr_o, 32'h0003_1234);
        xfer_i = 1; xfer_op32_i = 1; xfer_ip_i = 32'hFFFF_FFF0;
        step();
        chk("R7 near op32", eip_o, 32'hFFFF_FFF0);
        chk("R7 cs kept", base_of(CS), 32'h0003_0000);
        chk("R9 fetch wrap", fetch_addr_o, 32'h0002_FFF0);
        xfer_i = 1; xfer_far_i = 1; xfer_sel_i = 16'hF000; xfer_ip_i = 32'h0012_FFF0;
        step();
        chk("R8 far sel", sel_of(CS), 32'hF000);
        chk("R8 far base", base_of(CS), 32'h000F_0000);
        chk("R8 far trunc ip", eip_o, 32'h0000_FFF0);
        chk("R9 fetch far", fetch_addr_o, 32'h000F_FFF0);
        xfer_i = 1; xfer_far_i = 1; xfer_op32_i = 1; xfer_sel_i = 16'h2000; xfer_ip_i = 32'h0012_3456;
        step();
        chk("R8 far op32 ip", eip_o, 32'h0012_3456);
        chk("R8 far op32 base", base_of(CS), 32'h0002_0000);
        chk("R8 far limit kept", lim_of(CS), 32'hFFFF_FFFF);
        chk("R8 far attr kept", attr_of(CS), 32'h93);
    endtask

    task automatic t_smbase();
        smbase_wr_i = 1; smbase_wdata_i = 32'h000A_0000;
        step();
        chk("R10 smbase write", smbase_o, 32'h000A_0000);
        smi_entry_i = 1;
        step();
        chk("R10 entry sel new base", sel_of(CS), 32'hA000);
        chk("R10 entry base new", base_of(CS), 32'h000A_0000);
        smi_entry_i = 1; smbase_wr_i = 1; smbase_wdata_i = 32'h1111_0000;
        step();
        chk("R10 write dropped", smbase_o, 32'h000A_0000);
        chk("R10 entry old base", base_of(CS), 32'h000A_0000);
        chk("R4 cr0 stays", cr0_o, 32'h0000_0032);
    endtask

    task automatic t_priority();
        smi_entry_i = 1; seg_ld_i = 1; seg_ld_idx_i = 3'd3; seg_ld_sel_i = 16'h5555;
        xfer_i = 1; xfer_far_i = 1; xfer_sel_i = 16'h7777; xfer_ip_i = 32'h1;
        step();
        chk("R11 ds load lost", base_of(DS), 32'h0);
        chk("R11 far lost sel", sel_of(CS), 32'hA000);
        chk("R11 ip from entry", eip_o, 32'h0000_8000);
        seg_ld_i = 1; seg_ld_idx_i = 3'd1; seg_ld_sel_i = 16'h1111;
        xfer_i = 1; xfer_far_i = 1; xfer_sel_i = 16'h2222; xfer_ip_i = 32'h0000_0100;
        step();
        chk("R11 far over cs load", sel_of(CS), 32'h2222);
        chk("R11 far over cs base", base_of(CS), 32'h0002_2220);
        seg_ld_i = 1; seg_ld_idx_i = 3'd2; seg_ld_sel_i = 16'h0300;
        xfer_i = 1; xfer_ip_i = 32'h0000_0200;
        step();
        chk("R11 ss load with xfer", base_of(SS), 32'h0000_3000);
        chk("R11 xfer with ss load", eip_o, 32'h0000_0200);
        chk("R11 cs kept", sel_of(CS), 32'h2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        @(negedge clk);
        t_seg_load();
        t_entry();
        t_xfer();
        t_smbase();
        t_priority();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule